// File: doc/BRIEF.md
# Single-Master APB Decode and Read-Merge Fabric

This block joins one APB requester to a parameterised set of completer ports. It compares the requester address against one wildcard pattern per completer, where each pattern carries a care mask. The comparison yields one select line per completer, and each select is qualified by the requester's select. Enable, direction, write data and a narrowed local address go to every completer unchanged. Each completer returns its own read-data bus. The fabric forces the data of any unselected completer to zero and ORs the results, so the requester bus never has more than one driver and needs no tri-state net.

A minimal completer ships with the fabric for testing. It is a parallel output register that stores write data during an APB write access and returns the stored value when it is read. Each transfer has a setup cycle, with select high and enable low, and then an access cycle with both high. Address and control stay fixed across the two cycles. No wait states or error responses exist.

Top module: `apb_decode_fabric`

## Requirements
- R1: Completer select i is high exactly when the requester select is high and `(m_paddr ^ PAT_VAL[i]) & PAT_CARE[i]` is zero. By default completer i is matched by addresses `16'h1000 + 16*i` through `16'h100F + 16*i`, with care mask `16'hFFF0`.
- R2: Patterns that do not overlap never raise more than one completer select in the same cycle.
- R3: When the address matches no pattern, every completer select is low and `m_prdata` is all zeros.
- R4: `s_penable`, `s_pwrite` and `s_pwdata` equal `m_penable`, `m_pwrite` and `m_pwdata` in every cycle.
- R5: `s_paddr` carries the low `LW` bits (4 by default) of `m_paddr`.
- R6: `m_prdata` is the OR of every completer's read data ANDed with that completer's select. An unselected completer adds nothing, even when its data is nonzero.
- R7: The register completer loads `pwdata` on the rising clock edge when its select, enable and write are all high. In every other cycle it keeps its value, which covers a setup-only cycle and a read access.
- R8: A low `presetn` at a rising edge clears the register completer to zero. The reset is synchronous and active low.
- R9: The register completer drives its stored value on its read-data output. During a write access cycle, a read of the fabric therefore still shows the value held before that write.
- R10: With the requester select low, no completer select rises, even when the address matches a pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock, used by the checks |
| presetn | input | 1 | Active-low reset, used by the checks |
| m_psel | input | 1 | Requester select |
| m_penable | input | 1 | Requester enable (access phase) |
| m_pwrite | input | 1 | Requester direction, 1 = write |
| m_paddr | input | AW | Requester address |
| m_pwdata | input | DW | Requester write data |
| m_prdata | output | DW | Merged read data to the requester |
| s_psel | output | N | Qualified select, one bit per completer |
| s_penable | output | 1 | Broadcast enable |
| s_pwrite | output | 1 | Broadcast direction |
| s_paddr | output | LW | Broadcast local address |
| s_pwdata | output | DW | Broadcast write data |
| s_prdata | input | N*DW | Completer read data, completer i in bits [i*DW +: DW] |

## Verification
The case that needs care is a write to one completer and a read of the merged data landing in the same access cycle. The merge is combinational, while the register loads only at the closing edge. The bench opens a write access to each completer and samples `m_prdata` inside that access cycle, where it expects the previously written value. After the edge it reads back every completer and checks that only the addressed one changed. Sweeps cover every completer, every local offset, and unmapped addresses both inside and outside the decoded window.

// File: rtl/apb_outreg_slave.sv
module apb_outreg_slave #(
  parameter int DW = 16
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata
);
  logic [DW-1:0] store_q;
  wire wr_hit = psel & penable & pwrite;

  always_ff @(posedge pclk)
    if (!presetn)    store_q <= '0;
    else if (wr_hit) store_q <= pwdata;

  assign prdata = store_q;

  a_r7_capture: assert property (@(posedge pclk) disable iff (!presetn)
    wr_hit |=> prdata == $past(pwdata));
  a_r7_hold: assert property (@(posedge pclk) disable iff (!presetn)
    !wr_hit |=> $stable(prdata));
  a_r8_reset_clears: assert property (@(posedge pclk)
    !presetn |=> prdata == '0);
endmodule

// File: rtl/apb_decode_fabric.sv
module apb_decode_fabric #(
  parameter int N  = 4,
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int LW = 4,
  parameter logic [N*AW-1:0] PAT_VAL  = {16'h1030, 16'h1020, 16'h1010, 16'h1000},
  parameter logic [N*AW-1:0] PAT_CARE = {N{16'hFFF0}}
) (
  input  logic            pclk,
  input  logic            presetn,
  input  logic            m_psel,
  input  logic            m_penable,
  input  logic            m_pwrite,
  input  logic [AW-1:0]   m_paddr,
  input  logic [DW-1:0]   m_pwdata,
  output logic [DW-1:0]   m_prdata,
  output logic [N-1:0]    s_psel,
  output logic            s_penable,
  output logic            s_pwrite,
  output logic [LW-1:0]   s_paddr,
  output logic [DW-1:0]   s_pwdata,
  input  logic [N*DW-1:0] s_prdata
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign hit[i] = ((m_paddr ^ PAT_VAL[i*AW +: AW]) & PAT_CARE[i*AW +: AW]) == '0;

    a_r6_merge_selected: assert property (@(posedge pclk) disable iff (!presetn)
      s_psel[i] |-> m_prdata == s_prdata[i*DW +: DW]);
  end

  assign s_psel    = hit & {N{m_psel}};
  assign s_penable = m_penable;
  assign s_pwrite  = m_pwrite;
  assign s_paddr   = m_paddr[LW-1:0];
  assign s_pwdata  = m_pwdata;

  always_comb begin
    m_prdata = '0;
    for (int i = 0; i < N; i++)
      m_prdata |= s_prdata[i*DW +: DW] & {DW{s_psel[i]}};
  end

  a_r10_sel_needs_psel: assert property (@(posedge pclk) disable iff (!presetn)
    (s_psel != '0) |-> m_psel);
  a_r2_single_select: assert property (@(posedge pclk) disable iff (!presetn)
    $onehot0(s_psel));
  a_r3_idle_reads_zero: assert property (@(posedge pclk) disable iff (!presetn)
    (s_psel == '0) |-> (m_prdata == '0));
endmodule

// File: tb/test_apb_decode_fabric.sv
module test_apb_decode_fabric;
  localparam int N = 4, AW = 16, DW = 16, LW = 4;

  logic clk = 0, presetn = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] m_prdata;
  logic [N-1:0] s_psel;
  logic s_penable, s_pwrite;
  logic [LW-1:0] s_paddr;
  logic [DW-1:0] s_pwdata;
  logic [N*DW-1:0] s_prdata;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  logic [DW-1:0] model [N];

  always #5 clk = ~clk;

  apb_decode_fabric #(.N(N), .AW(AW), .DW(DW), .LW(LW)) i_apb_decode_fabric (
    .pclk(clk), .presetn(presetn), .m_psel(psel), .m_penable(penable),
    .m_pwrite(pwrite), .m_paddr(paddr), .m_pwdata(pwdata), .m_prdata(m_prdata),
    .s_psel(s_psel), .s_penable(s_penable), .s_pwrite(s_pwrite),
    .s_paddr(s_paddr), .s_pwdata(s_pwdata), .s_prdata(s_prdata));

  for (genvar i = 0; i < N; i++) begin : g_reg
    apb_outreg_slave #(.DW(DW)) u_reg (
      .pclk(clk), .presetn(presetn), .psel(s_psel[i]), .penable(s_penable),
      .pwrite(s_pwrite), .pwdata(s_pwdata), .prdata(s_prdata[i*DW +: DW]));
  end

  function automatic logic [N-1:0] exp_sel(input logic [AW-1:0] a, input logic s);
    exp_sel = '0;
    for (int i = 0; i < N; i++)
      if (s && (a >> 4) == (16'h100 + i)) exp_sel[i] = 1'b1;
  endfunction

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    exp_rd = '0;
    for (int i = 0; i < N; i++)
      if ((a >> 4) == (16'h100 + i)) exp_rd = model[i];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit probe);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    #1;
    check(s_psel == exp_sel(a, 1), "R1", 32'(s_psel), 32'(exp_sel(a, 1)));
    check(s_paddr == a[LW-1:0], "R5", 32'(s_paddr), 32'(a[LW-1:0]));
    check(s_pwdata == d && s_pwrite == 1 && s_penable == 0, "R4", 32'(s_pwdata), 32'(d));
    @(negedge clk); penable = 1;
    #1;
    if (probe) check(m_prdata == exp_rd(a), "R9 old value during write", 32'(m_prdata), 32'(exp_rd(a)));
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    for (int i = 0; i < N; i++)
      if ((a >> 4) == (16'h100 + i)) model[i] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1;
    check(m_prdata == exp_rd(a), req, 32'(m_prdata), 32'(exp_rd(a)));
    check($countones(s_psel) <= 1, "R2", 32'(s_psel), 32'(exp_sel(a, 1)));
    @(negedge clk); psel = 0; penable = 0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    presetn = 1;
    for (int i = 0; i < N; i++) do_read(16'h1000 + 16*i, "R8 reset state");

    for (int i = 0; i < N; i++) do_write(16'h1000 + 16*i + i, 16'hA000 + 16'(i*17), 1);
    for (int i = 0; i < N; i++)
      for (int off = 0; off < 16; off++) do_read(16'h1000 + 16*i + off, "R6 readback");

    for (int k = 0; k < N; k++) begin
      do_write(16'h1000 + 16*k + 15, 16'h5A00 ^ 16'(k*16'h0101), 1);
      for (int i = 0; i < N; i++) do_read(16'h1000 + 16*i, "R7 neighbour unchanged");
    end

    foreach (paddr[b]) begin end
    for (int u = 0; u < 8; u++) do_read(16'h0FF0 + 16'(u*16'h0200) + 16'(u), "R3 unmapped read");
    do_read(16'h1040, "R3 just above window");
    do_read(16'h0FFF, "R3 just below window");
    do_write(16'h2000, 16'hDEAD, 0);
    for (int i = 0; i < N; i++) do_read(16'h1000 + 16*i, "R3 unmapped write ignored");

    @(negedge clk); psel = 0; paddr = 16'h1010; penable = 1; pwrite = 1; pwdata = 16'hBEEF;
    #1;
    check(s_psel == '0, "R10 psel low", 32'(s_psel), 32'h0);
    check(m_prdata == '0, "R6 unselected gated", 32'(m_prdata), 32'h0);
    @(negedge clk); penable = 0; pwrite = 0;
    do_read(16'h1010, "R7 write without psel ignored");

    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 16'h1020; pwdata = 16'h1234;
    @(negedge clk); psel = 0;
    do_read(16'h1020, "R7 setup-only ignored");

    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = 16'h1030; pwdata = 16'h7777;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0;
    do_read(16'h1030, "R7 read access ignored");

    @(negedge clk); presetn = 0;
    @(negedge clk); presetn = 1;
    for (int i = 0; i < N; i++) model[i] = '0;
    for (int i = 0; i < N; i++) do_read(16'h1000 + 16*i, "R8 mid-run reset");

    finish_run();
  end
endmodule